// File: doc/BRIEF.md
# Interrupt Branch Gate Arbiter

This block decides when a pending interrupt may redirect a single-thread processor that has three interrupt levels. Each level captures its event from one of two sources: an external pulse, or an exact match between a free-running counter and a compare value. The captured event stays pending until that level is granted.

A grant is held back while the instruction in flight is in a state that must not be split. These states are index-alter instructions, scaled multiplies, queue-setup prefixes, augment prefixes that are waiting for their consumer, repeat blocks, stall-interrupt regions and timed waits. The augment wait and the timed-wait length are tracked inside the block. Once the gate is open, the highest-priority eligible level receives a one-cycle one-hot grant and a vector select. Levels of equal or lower priority than a routine that is still running are masked until that routine returns.

Top module: `irq_gate_arbiter`

## Requirements
- R1: An event for level k sets its pending flag at the next clock edge. The flag stays set, through any number of blocked cycles, until level k is granted.
- R2: When `ev_sel_cmp_i[k]` is 1, level k's event is the counter match alone, and `ev_i[k]` has no effect. The match fires only in a cycle where `ct_i` equals `ct_cmp_i` exactly.
- R3: `gate_open_o` is 0 and no grant is issued while `alt_exec_i`, `scl_exec_i` or `setq_exec_i` is 1.
- R4: An augment prefix blocks from the cycle in which `aug_exec_i` is 1 through the cycle in which `aug_use_i` marks its consumer, inclusive. The gate opens on the cycle after that.
- R5: `rep_exec_i`, `rep_active_i`, `stall_exec_i` and `stall_active_i` each block the gate while they are 1.
- R6: A timed wait started by `wait_go_i` with length N blocks for max(N,1) cycles, counting from the start cycle.
- R7: With the gate open, `grant_o` is one-hot on the eligible pending level with the lowest index (bit 0 = INT1, the highest priority). `vec_sel_o` is the level index plus 1, or 0 when there is no grant. `gate_open_o` is 1 exactly when no block condition holds.
- R8: A grant clears its level's pending flag at the next edge. A new event for that level in the grant cycle leaves the flag set.
- R9: A grant marks its level as active, and `ret_i[k]` clears that mark. While level j is active, no level k with k >= j is granted.
- R10: During and right after reset, nothing is pending or active, the wait timer is idle, and `grant_o` and `vec_sel_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | NUM_LVL | External event pulse per level |
| ev_sel_cmp_i | input | NUM_LVL | Per level: 1 selects the counter match as the event source |
| ct_i | input | CT_W | Free-running counter value |
| ct_cmp_i | input | CT_W | Compare value for the counter match |
| alt_exec_i | input | 1 | Index-alter instruction executing |
| scl_exec_i | input | 1 | Scaled multiply executing |
| setq_exec_i | input | 1 | Queue-setup prefix executing |
| aug_exec_i | input | 1 | Augment prefix executing |
| aug_use_i | input | 1 | Instruction consuming the augment value executing |
| rep_exec_i | input | 1 | Repeat instruction executing |
| rep_active_i | input | 1 | Repeat block in progress |
| stall_exec_i | input | 1 | Stall-interrupt instruction executing |
| stall_active_i | input | 1 | Stall-interrupt mode in force |
| wait_go_i | input | 1 | Timed wait starts this cycle |
| wait_len_i | input | WAIT_W | Timed-wait length in cycles |
| ret_i | input | NUM_LVL | Return strobe per level |
| grant_o | output | NUM_LVL | One-hot branch grant |
| vec_sel_o | output | SEL_W | Granted level plus 1, or 0 when idle |
| gate_open_o | output | 1 | No block condition this cycle |

## Verification
The bench goes after the case where a timed wait is blocked only on its first cycle. A design with that fault grants in the middle of the wait, which is the failure this block exists to prevent. It also holds an augment prefix across idle cycles before its consumer arrives; a gate that only looks at the prefix's own cycle would open too early. Nested service is checked in both directions: a higher level must preempt a running lower one, and equal or lower levels must stay masked until their return strobe. An event that repeats in its own grant cycle must remain pending, and a design that lets the clear win would lose it. The counter match is checked for exact equality, and the external pulse is checked to have no effect on a level that selects the counter.

// File: rtl/irq_gate_pkg.sv
`timescale 1ns/1ps
package irq_gate_pkg;
  // reasons that hold the branch off; any set bit closes the gate
  typedef struct packed {
    logic alt;
    logic scl;
    logic setq;
    logic aug;
    logic rep;
    logic stall;
    logic wait_t;
  } blk_t;
endpackage

// File: rtl/irq_cmp_event.sv
`timescale 1ns/1ps
module irq_cmp_event #(
  parameter int unsigned NUM_LVL = 3,
  parameter int unsigned CT_W    = 32
) (
  input  logic [NUM_LVL-1:0] ev_i,
  input  logic [NUM_LVL-1:0] sel_cmp_i,
  input  logic [CT_W-1:0]    ct_i,
  input  logic [CT_W-1:0]    ct_cmp_i,
  output logic [NUM_LVL-1:0] ev_o
);
  logic hit;
  assign hit = (ct_i == ct_cmp_i);  // exact match only; a missed instant waits for wrap

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_src
    assign ev_o[k] = sel_cmp_i[k] ? hit : ev_i[k];
  end
endmodule

// File: rtl/irq_block_gate.sv
`timescale 1ns/1ps
module irq_block_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_exec_i,
  input  logic              scl_exec_i,
  input  logic              setq_exec_i,
  input  logic              aug_exec_i,
  input  logic              aug_use_i,
  input  logic              rep_exec_i,
  input  logic              rep_active_i,
  input  logic              stall_exec_i,
  input  logic              stall_active_i,
  input  logic              wait_go_i,
  input  logic [WAIT_W-1:0] wait_len_i,
  output logic              open_o
);
  logic [WAIT_W-1:0] remain_q;
  logic              aug_armed_q;
  blk_t              blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
    end else if (wait_go_i) begin
      remain_q <= (wait_len_i == '0) ? '0 : wait_len_i - 1'b1;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  // prefix stays armed until its consumer executes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aug_armed_q <= 1'b0;
    end else if (aug_exec_i) begin
      aug_armed_q <= 1'b1;
    end else if (aug_use_i) begin
      aug_armed_q <= 1'b0;
    end
  end

  always_comb begin
    blk.alt    = alt_exec_i;
    blk.scl    = scl_exec_i;
    blk.setq   = setq_exec_i;
    blk.aug    = aug_exec_i | aug_armed_q;
    blk.rep    = rep_exec_i | rep_active_i;
    blk.stall  = stall_exec_i | stall_active_i;
    blk.wait_t = wait_go_i | (remain_q != '0);
  end

  assign open_o = ~(|blk);

  assert_wait_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_go_i && wait_len_i > 2) |=> !open_o);
  assert_aug_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aug_exec_i |=> !open_o);
  assert_aug_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aug_armed_q && aug_use_i && !aug_exec_i) |=> !aug_armed_q);
endmodule

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank #(
  parameter int unsigned NUM_LVL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] ev_i,
  input  logic [NUM_LVL-1:0] grant_i,
  input  logic [NUM_LVL-1:0] ret_i,
  output logic [NUM_LVL-1:0] pend_o,
  output logic [NUM_LVL-1:0] active_o
);
  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    logic pend_q, act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        act_q  <= 1'b0;
      end else begin
        pend_q <= (pend_q & ~grant_i[k]) | ev_i[k];  // new event beats the clear
        act_q  <= (act_q & ~ret_i[k]) | grant_i[k];
      end
    end

    assign pend_o[k]   = pend_q;
    assign active_o[k] = act_q;

    assert_pend_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && !grant_i[k]) |=> pend_q);
    assert_pend_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_i[k] && !ev_i[k]) |=> !pend_q);
    assert_grant_needs_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_i[k] |-> pend_q);
  end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int unsigned NUM_LVL = 3,
  parameter int unsigned SEL_W   = $clog2(NUM_LVL + 1)
) (
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [NUM_LVL-1:0] active_i,
  input  logic               open_i,
  output logic [NUM_LVL-1:0] grant_o,
  output logic [SEL_W-1:0]   vec_sel_o
);
  logic [NUM_LVL-1:0] act_upto;  // some level at or above k is active
  logic [NUM_LVL-1:0] elig;
  logic [NUM_LVL-1:0] taken;     // an eligible level exists at or above k

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_pick
    if (k == 0) begin : g_first
      assign act_upto[k] = active_i[k];
      assign elig[k]     = pend_i[k] & open_i & ~act_upto[k];
      assign grant_o[k]  = elig[k];
      assign taken[k]    = elig[k];
    end else begin : g_rest
      assign act_upto[k] = act_upto[k-1] | active_i[k];
      assign elig[k]     = pend_i[k] & open_i & ~act_upto[k];
      assign grant_o[k]  = elig[k] & ~taken[k-1];
      assign taken[k]    = taken[k-1] | elig[k];
    end
  end

  always_comb begin
    vec_sel_o = '0;
    for (int k = NUM_LVL - 1; k >= 0; k--) begin
      if (grant_o[k]) vec_sel_o = SEL_W'(k + 1);
    end
  end
endmodule

// File: rtl/irq_gate_arbiter.sv
`timescale 1ns/1ps
module irq_gate_arbiter #(
  parameter int unsigned NUM_LVL = 3,
  parameter int unsigned CT_W    = 32,
  parameter int unsigned WAIT_W  = 16,
  localparam int unsigned SEL_W  = $clog2(NUM_LVL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] ev_i,
  input  logic [NUM_LVL-1:0] ev_sel_cmp_i,
  input  logic [CT_W-1:0]    ct_i,
  input  logic [CT_W-1:0]    ct_cmp_i,
  input  logic               alt_exec_i,
  input  logic               scl_exec_i,
  input  logic               setq_exec_i,
  input  logic               aug_exec_i,
  input  logic               aug_use_i,
  input  logic               rep_exec_i,
  input  logic               rep_active_i,
  input  logic               stall_exec_i,
  input  logic               stall_active_i,
  input  logic               wait_go_i,
  input  logic [WAIT_W-1:0]  wait_len_i,
  input  logic [NUM_LVL-1:0] ret_i,
  output logic [NUM_LVL-1:0] grant_o,
  output logic [SEL_W-1:0]   vec_sel_o,
  output logic               gate_open_o
);
  logic [NUM_LVL-1:0] ev_lvl;
  logic [NUM_LVL-1:0] pend;
  logic [NUM_LVL-1:0] active;
  logic               open;

  irq_cmp_event #(.NUM_LVL(NUM_LVL), .CT_W(CT_W)) u_cmp (
    .ev_i      (ev_i),
    .sel_cmp_i (ev_sel_cmp_i),
    .ct_i      (ct_i),
    .ct_cmp_i  (ct_cmp_i),
    .ev_o      (ev_lvl)
  );

  irq_block_gate #(.WAIT_W(WAIT_W)) u_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alt_exec_i     (alt_exec_i),
    .scl_exec_i     (scl_exec_i),
    .setq_exec_i    (setq_exec_i),
    .aug_exec_i     (aug_exec_i),
    .aug_use_i      (aug_use_i),
    .rep_exec_i     (rep_exec_i),
    .rep_active_i   (rep_active_i),
    .stall_exec_i   (stall_exec_i),
    .stall_active_i (stall_active_i),
    .wait_go_i      (wait_go_i),
    .wait_len_i     (wait_len_i),
    .open_o         (open)
  );

  irq_pend_bank #(.NUM_LVL(NUM_LVL)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_lvl),
    .grant_i  (grant_o),
    .ret_i    (ret_i),
    .pend_o   (pend),
    .active_o (active)
  );

  irq_prio_pick #(.NUM_LVL(NUM_LVL), .SEL_W(SEL_W)) u_pick (
    .pend_i    (pend),
    .active_i  (active),
    .open_i    (open),
    .grant_o   (grant_o),
    .vec_sel_o (vec_sel_o)
  );

  assign gate_open_o = open;

  assert_grant_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_no_grant_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_exec_i || scl_exec_i || setq_exec_i) |-> (grant_o == '0));
  assert_block_rep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_active_i || stall_active_i) |-> !gate_open_o);
  assert_top_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active[0] |-> (grant_o == '0));
  assert_vec_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> (vec_sel_o != '0));
endmodule

// File: tb/irq_gate_arbiter_tb.sv
`timescale 1ns/1ps
module irq_gate_arbiter_tb;
  localparam int NL = 3;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] ev = '0, sel_cmp = '0, ret = '0;
  logic [31:0]   ct = 32'd0, ct_cmp = 32'd100;
  logic [6:0]    blk = '0;  // alt, scl, setq, rep_exec, rep_act, stall_exec, stall_act
  logic          aug_exec = 1'b0, aug_use = 1'b0, wait_go = 1'b0;
  logic [WW-1:0] wait_len = '0;
  logic [NL-1:0] grant;
  logic [1:0]    vec_sel;
  logic          gate_open;
  int            errs = 0, checks = 0;

  always #4 clk = ~clk;

  irq_gate_arbiter #(.NUM_LVL(NL), .CT_W(32), .WAIT_W(WW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ev_i(ev), .ev_sel_cmp_i(sel_cmp),
    .ct_i(ct), .ct_cmp_i(ct_cmp),
    .alt_exec_i(blk[0]), .scl_exec_i(blk[1]), .setq_exec_i(blk[2]),
    .aug_exec_i(aug_exec), .aug_use_i(aug_use),
    .rep_exec_i(blk[3]), .rep_active_i(blk[4]),
    .stall_exec_i(blk[5]), .stall_active_i(blk[6]),
    .wait_go_i(wait_go), .wait_len_i(wait_len), .ret_i(ret),
    .grant_o(grant), .vec_sel_o(vec_sel), .gate_open_o(gate_open)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic look(input string tag, input int g, input int v, input int o);
    #1;
    chk({tag, " grant"}, int'(grant), g);
    chk({tag, " vec"}, int'(vec_sel), v);
    chk({tag, " open"}, int'(gate_open), o);
  endtask

  task automatic ev_pulse(input logic [NL-1:0] m);
    ev = m; nxt(); ev = '0;
  endtask

  task automatic ret_pulse(input logic [NL-1:0] m);
    ret = m; nxt(); ret = '0;
  endtask

  task automatic t_reset();
    ev = 3'b111;
    look("R10 in reset", 0, 0, 1);
    nxt(); nxt();
    ev = '0;
    rst_ni = 1'b1;
    look("R10 after reset", 0, 0, 1);
    nxt();
    look("R10 idle", 0, 0, 1);
  endtask

  task automatic t_basic();
    ev_pulse(3'b100);
    look("R1 capture", 4, 3, 1);
    nxt();
    look("R8 cleared", 0, 0, 1);
    ret_pulse(3'b100);
  endtask

  task automatic t_priority();
    blk[0] = 1'b1;
    ev_pulse(3'b111);
    look("R3 alt blocks", 0, 0, 0);
    nxt();
    look("R1 held while blocked", 0, 0, 0);
    blk[0] = 1'b0;
    look("R7 top first", 1, 1, 1);
    nxt();
    look("R9 masked by INT1", 0, 0, 1);
    ret = 3'b001;
    look("R9 ret cycle", 0, 0, 1);
    nxt(); ret = '0;
    look("R7 second", 2, 2, 1);
    nxt();
    look("R9 masked by INT2", 0, 0, 1);
    ret = 3'b010;
    nxt(); ret = '0;
    look("R7 third", 4, 3, 1);
    nxt();
    ret_pulse(3'b100);
  endtask

  task automatic t_blocker(input int idx, input string tag);
    blk = 7'(1 << idx);
    ev_pulse(3'b100);
    look(tag, 0, 0, 0);
    blk = '0;
    look({tag, " released"}, 4, 3, 1);
    nxt();
    ret_pulse(3'b100);
  endtask

  task automatic t_preempt();
    ev_pulse(3'b010);
    look("R9 low grant", 2, 2, 1);
    nxt();
    ev_pulse(3'b001);
    look("R9 preempt", 1, 1, 1);
    nxt();
    ev_pulse(3'b010);
    look("R9 equal masked", 0, 0, 1);
    ret_pulse(3'b001);
    look("R9 still nested", 0, 0, 1);
    ret_pulse(3'b010);
    look("R9 pending served", 2, 2, 1);
    nxt();
    ret_pulse(3'b010);
  endtask

  task automatic t_repeat_event();
    ev_pulse(3'b100);
    ev = 3'b100;
    look("R8 grant with event", 4, 3, 1);
    nxt(); ev = '0;
    look("R8 masked", 0, 0, 1);
    ret_pulse(3'b100);
    look("R8 kept pending", 4, 3, 1);
    nxt();
    ret_pulse(3'b100);
  endtask

  task automatic t_aug();
    aug_exec = 1'b1; ev = 3'b100;
    look("R4 prefix cycle", 0, 0, 0);
    nxt(); aug_exec = 1'b0; ev = '0;
    look("R4 waiting 1", 0, 0, 0);
    nxt();
    look("R4 waiting 2", 0, 0, 0);
    aug_use = 1'b1;
    look("R4 consumer cycle", 0, 0, 0);
    nxt(); aug_use = 1'b0;
    look("R4 released", 4, 3, 1);
    nxt();
    ret_pulse(3'b100);
  endtask

  task automatic t_wait();
    wait_go = 1'b1; wait_len = 16'd3; ev = 3'b100;
    look("R6 start", 0, 0, 0);
    nxt(); wait_go = 1'b0; ev = '0;
    look("R6 mid 1", 0, 0, 0);
    nxt();
    look("R6 mid 2", 0, 0, 0);
    nxt();
    look("R6 done", 4, 3, 1);
    nxt();
    ret_pulse(3'b100);
    wait_go = 1'b1; wait_len = 16'd0; ev = 3'b100;
    look("R6 zero len", 0, 0, 0);
    nxt(); wait_go = 1'b0; ev = '0;
    look("R6 zero len done", 4, 3, 1);
    nxt();
    ret_pulse(3'b100);
  endtask

  task automatic t_cmp();
    sel_cmp = 3'b010; ct = 32'd5; ct_cmp = 32'd6;
    ev_pulse(3'b010);
    look("R2 pulse ignored", 0, 0, 1);
    ct = 32'd6;
    nxt(); ct = 32'd7;
    look("R2 match fires", 2, 2, 1);
    nxt();
    look("R2 one shot", 0, 0, 1);
    ret_pulse(3'b010);
    look("R2 no refire", 0, 0, 1);
    sel_cmp = '0;
  endtask

  initial begin
    #(8 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    nxt();
    t_reset();
    t_basic();
    t_priority();
    t_blocker(0, "R3 alt");
    t_blocker(1, "R3 scl");
    t_blocker(2, "R3 setq");
    t_blocker(3, "R5 rep exec");
    t_blocker(4, "R5 rep active");
    t_blocker(5, "R5 stall exec");
    t_blocker(6, "R5 stall active");
    t_preempt();
    t_repeat_event();
    t_aug();
    t_wait();
    t_cmp();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule